// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block gathers the external interrupt sources of a small 8-bit microcontroller and presents them to the CPU as one request line. The main source is an active-low IRQ pin. Four port pins can be folded into it when the block is built for that. A second source comes from its own active-low pin. Each pin passes through a two-flop synchronizer and an edge-tracking state machine. A pending-flag state machine holds each event until software acknowledges it.

Software reaches the block through one status/control byte on a plain strobe bus. That byte holds both enable bits and both pending flags, and it takes the write-one-to-clear acknowledge bits for the two flags. Both sources share one vector, and the block drives out the two vector byte addresses as constants. The synchronized level of the combined IRQ input is also driven out, for branch-on-pin instructions.

The edge state machine (`ext_irq_sync`) has two states. `EDG_HIGH` moves to `EDG_LOW` when the synchronized input reads 0; that transition is the falling-edge event. `EDG_LOW` returns to `EDG_HIGH` when the input reads 1. The flag state machine (`ext_irq_flag`) also has two states. `FLG_IDLE` moves to `FLG_PEND` on a set. `FLG_PEND` returns to `FLG_IDLE` on an acknowledge, but only when no set arrives in the same cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, both enables and both pending flags read 0, the request output is 0 and the pin-level output is 1.
- R2: The request output is 1 exactly when the IRQ flag and the IRQ enable (bit 7) are both set, or when the IRQ2 flag and the IRQ2 enable (bit 6) are both set.
- R3: A pending flag clears only when software writes 1 to its acknowledge bit. Bit 1 acknowledges the IRQ flag and bit 0 acknowledges the IRQ2 flag. Writing 0 to these bits leaves the flags unchanged.
- R4: A falling edge on the combined IRQ input sets the IRQ flag (read at bit 3). The flag is visible on the third rising clock edge after the pin goes low. In edge-only mode (LEVEL_SENS=0), an input held low does not set the flag again after it is acknowledged.
- R5: With LEVEL_SENS=1, the IRQ flag is set on every clock while the synchronized IRQ input is low, so an acknowledge does not clear it until the pin has returned high.
- R6: A falling edge on the IRQ2 pin sets the IRQ2 flag (read at bit 2). The IRQ2 enable only gates the request; the flag is set whether or not the enable is set.
- R7: If a set event and an acknowledge for the same flag land in the same cycle, the flag stays pending.
- R8: On a read, bits 5, 4, 1 and 0 of the register return 0.
- R9: The vector high-byte address output is 0x1FFA and the low-byte address output is 0x1FFB.
- R10: With PORT_MERGE=1, any of the four port pins going high acts as a falling edge on the combined IRQ input.
- R11: The pin-level output follows the combined IRQ input, active low, two clock edges late.
- R12: Writes to any address other than REG_ADDR change nothing, and reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Main interrupt pin, active low |
| port_pins | input | NUM_PORT | Port pins merged into the IRQ input, active high |
| irq2_pin_n | input | 1 | Second interrupt pin, falling-edge sensitive |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (0 when not selected) |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_level_o | output | 1 | Synchronized level of the combined IRQ input |
| vec_hi_addr_o | output | 16 | Address of the vector high byte |
| vec_lo_addr_o | output | 16 | Address of the vector low byte |

## Verification
If a flag state machine is stuck or lost its state, the wrong value shows on the register read-back and on `irq_req_o` within three clock edges of the pin event or one edge after the acknowledge write. If the edge state machine is wrong, the flag either sets again after an acknowledge while the pin is held low, or never sets at all. Both cases show at the next read. If the set-versus-clear priority is inverted, the flag reads 0 after a coincident edge and acknowledge, so that event is lost.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic {EDG_HIGH, EDG_LOW} edge_state_t;
    typedef enum logic {FLG_IDLE, FLG_PEND} flag_state_t;

    localparam int BIT_EN_IRQ   = 7;
    localparam int BIT_EN_IRQ2  = 6;
    localparam int BIT_FLG_IRQ  = 3;
    localparam int BIT_FLG_IRQ2 = 2;
    localparam int BIT_ACK_IRQ  = 1;
    localparam int BIT_ACK_IRQ2 = 0;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync
    import ext_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe;
    edge_state_t st_q, st_d;

    // synchronizer chain, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], pin_n};
    end

    assign level_o = pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDG_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        fall_o = 1'b0;
        unique case (st_q)
            EDG_HIGH: if (!level_o) begin
                st_d   = EDG_LOW;
                fall_o = 1'b1;
            end
            EDG_LOW:  if (level_o) st_d = EDG_HIGH;
            default:  st_d = EDG_HIGH;
        endcase
    end
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    // set has priority over clear so no event is dropped
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: if (set_i) st_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) st_d = FLG_IDLE;
            default:  st_d = FLG_IDLE;
        endcase
    end

    assign flag_o = (st_q == FLG_PEND);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0A,
    parameter int              NUM_PORT   = 4,
    parameter bit              PORT_MERGE = 1'b1,
    parameter bit              LEVEL_SENS = 1'b0,
    parameter logic [15:0]     VEC_HI     = 16'h1FFA,
    parameter logic [15:0]     VEC_LO     = 16'h1FFB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pins,
    input  logic                irq2_pin_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [7:0]          bus_rdata,
    output logic                irq_req_o,
    output logic                irq_level_o,
    output logic [15:0]         vec_hi_addr_o,
    output logic [15:0]         vec_lo_addr_o
);
    localparam int NSRC = 2;

    logic            merged_n;
    logic [NSRC-1:0] src_n, sync_lvl, fall, set, clr, flag, en;
    logic            wr_hit, rd_hit;

    generate
        if (PORT_MERGE) begin : g_merge
            assign merged_n = irq_pin_n & ~(|port_pins);
        end else begin : g_nomerge
            assign merged_n = irq_pin_n;
        end
    endgenerate

    assign src_n  = {irq2_pin_n, merged_n};
    assign wr_hit = bus_wr && (bus_addr == REG_ADDR);
    assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

    assign clr[0] = wr_hit && bus_wdata[BIT_ACK_IRQ];
    assign clr[1] = wr_hit && bus_wdata[BIT_ACK_IRQ2];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        ext_irq_sync #(.STAGES(2)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_n(src_n[g]),
            .level_o(sync_lvl[g]), .fall_o(fall[g])
        );
        if (g == 0 && LEVEL_SENS) begin : g_lvl
            assign set[g] = fall[g] | ~sync_lvl[g];
        end else begin : g_edge
            assign set[g] = fall[g];
        end
        ext_irq_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(set[g]),
            .clr_i(clr[g]), .flag_o(flag[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_hit) begin
            en[0] <= bus_wdata[BIT_EN_IRQ];
            en[1] <= bus_wdata[BIT_EN_IRQ2];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[BIT_EN_IRQ]   = en[0];
            bus_rdata[BIT_EN_IRQ2]  = en[1];
            bus_rdata[BIT_FLG_IRQ]  = flag[0];
            bus_rdata[BIT_FLG_IRQ2] = flag[1];
        end
    end

    assign irq_req_o     = |(flag & en);
    assign irq_level_o   = sync_lvl[0];
    assign vec_hi_addr_o = VEC_HI;
    assign vec_lo_addr_o = VEC_LO;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] flag,
    input logic [1:0] en,
    input logic [1:0] clr,
    input logic [1:0] set,
    input logic [1:0] fall,
    input logic       irq_req_o,
    input logic [7:0] bus_rdata
);
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag[0] && !clr[0] |=> flag[0]);
    a_r3_flag2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag[1] && !clr[1] |=> flag[1]);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set[0] && clr[0] |=> flag[0]);
    a_r6_flag2_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[1]) |-> $past(fall[1]));
    a_r2_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 2'b00) |-> !irq_req_o);
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[5:4] == 2'b00 && bus_rdata[1:0] == 2'b00);
endmodule

bind ext_irq_ctrl ext_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flag(flag), .en(en), .clr(clr),
    .set(set), .fall(fall), .irq_req_o(irq_req_o), .bus_rdata(bus_rdata)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
    localparam logic [7:0] RA = 8'h0A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_a_n = 1'b1, irq_b_n = 1'b1, irq2_n = 1'b1;
    logic [3:0] ports = '0;
    logic [7:0] addr = '0, wdata = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata_a, rdata_b;
    logic req_a, req_b, lvl_a, lvl_b;
    logic [15:0] vh_a, vl_a, vh_b, vl_b;

    int n_chk = 0, n_fail = 0;
    bit m_en1, m_en2, m_f1, m_f2;

    always #2.5 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_a_n), .port_pins(ports),
        .irq2_pin_n(irq2_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
        .bus_rd(rd), .bus_rdata(rdata_a), .irq_req_o(req_a),
        .irq_level_o(lvl_a), .vec_hi_addr_o(vh_a), .vec_lo_addr_o(vl_a)
    );

    ext_irq_ctrl #(.LEVEL_SENS(1'b1), .PORT_MERGE(1'b0)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_b_n), .port_pins(ports),
        .irq2_pin_n(irq2_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
        .bus_rd(rd), .bus_rdata(rdata_b), .irq_req_o(req_b),
        .irq_level_o(lvl_b), .vec_hi_addr_o(vh_b), .vec_lo_addr_o(vl_b)
    );

    function automatic logic [7:0] exp_reg(bit e1, bit e2, bit f1, bit f2);
        return {e1, e2, 2'b00, f1, f2, 2'b00};
    endfunction

    function automatic logic exp_req(bit e1, bit e2, bit f1, bit f2);
        return (e1 & f1) | (e2 & f2);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] da, output logic [7:0] db);
        @(negedge clk); addr = a; rd = 1'b1;
        #1; da = rdata_a; db = rdata_b;
        rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_model(string tag);
        logic [7:0] da, db;
        bus_read(RA, da, db);
        check({tag, " reg"}, da, exp_reg(m_en1, m_en2, m_f1, m_f2));
        check({tag, " req R2"}, req_a, exp_req(m_en1, m_en2, m_f1, m_f2));
    endtask

    // watchdog
    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] da, db;
        void'($urandom(32'h5EED));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        bus_read(RA, da, db);
        check("R1 reg", da, 8'h00);
        check("R1 req", req_a, 1'b0);
        check("R1 level", lvl_a, 1'b1);
        // R9 vectors
        check("R9 hi", vh_a, 16'h1FFA);
        check("R9 lo", vl_a, 16'h1FFB);

        // R11 / R4 timing: pin low before edge k
        @(negedge clk); irq_a_n = 1'b0;
        @(negedge clk); check("R11 one edge", lvl_a, 1'b1);
        @(negedge clk); check("R11 two edges", lvl_a, 1'b0);
        bus_read(RA, da, db);               // after third edge
        check("R4 flag after 3 edges", da[3], 1'b1);
        check("R2 req gated by enable", req_a, 1'b0);
        m_f1 = 1;

        // R7 set wins: release pin, then new edge coincides with ack
        irq_a_n = 1'b1; idle(4);
        bus_write(RA, 8'h80); m_en1 = 1;
        check("R2 req enabled", req_a, 1'b1);
        @(negedge clk); irq_a_n = 1'b0;
        @(negedge clk);
        bus_write(RA, 8'h82);               // ack lands on the edge cycle
        bus_read(RA, da, db);
        check("R7 set wins", da[3], 1'b1);

        // R4 held low, edge-only: ack clears and it stays clear
        bus_write(RA, 8'h82); m_f1 = 0;
        idle(4);
        bus_read(RA, da, db);
        check("R4 no re-set while low", da[3], 1'b0);
        check("R3 req dropped after ack", req_a, 1'b0);
        irq_a_n = 1'b1; idle(4);

        // R6: IRQ2 flag with enable clear, then enabled
        @(negedge clk); irq2_n = 1'b0;
        @(negedge clk); irq2_n = 1'b1; idle(4);
        m_f2 = 1;
        bus_read(RA, da, db);
        check("R6 flag2 set", da[2], 1'b1);
        bus_write(RA, 8'h00); m_en1 = 0;
        check("R6 req off when disabled", req_a, 1'b0);
        bus_write(RA, 8'h40); m_en2 = 1;
        check("R6 req on when enabled", req_a, 1'b1);

        // R3 writing zero to ack leaves flag
        bus_write(RA, 8'h40);
        check_model("R3 zero ack");
        // R12 other address ignored
        bus_write(8'h0B, 8'h03);
        check_model("R12 other addr write");
        bus_read(8'h0B, da, db);
        check("R12 other addr read", da, 8'h00);
        // R8 reserved bits read zero with all written ones
        bus_write(RA, 8'hFC);
        bus_read(RA, da, db);
        check("R8 reserved zero", {da[5:4], da[1:0]}, 4'h0);
        m_en1 = 1; m_en2 = 1;
        bus_write(RA, 8'h03); m_en1 = 0; m_en2 = 0; m_f2 = 0;
        check_model("R3 ack clears");

        // R10 port pin merged into IRQ
        @(negedge clk); ports = 4'b0100;
        @(negedge clk); ports = 4'b0000; idle(4);
        m_f1 = 1;
        check_model("R10 port merge");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op = $urandom_range(0, 3);
            case (op)
                0: begin
                    logic [7:0] d = 8'($urandom);
                    logic hit = ($urandom_range(0, 3) != 0);
                    bus_write(hit ? RA : 8'h33, d);
                    if (hit) begin
                        m_en1 = d[7]; m_en2 = d[6];
                        if (d[1]) m_f1 = 0;
                        if (d[0]) m_f2 = 0;
                    end
                    check_model("R3 R12 random write");
                end
                1: begin
                    int n = $urandom_range(1, 3);
                    @(negedge clk); irq_a_n = 1'b0;
                    idle(n); irq_a_n = 1'b1; idle(4);
                    m_f1 = 1;
                    check_model("R4 random irq");
                end
                2: begin
                    int n = $urandom_range(1, 3);
                    @(negedge clk); irq2_n = 1'b0;
                    idle(n); irq2_n = 1'b1; idle(4);
                    m_f2 = 1;
                    check_model("R6 random irq2");
                end
                default: begin
                    @(negedge clk); ports = 4'(1 << $urandom_range(0, 3));
                    idle(2); ports = '0; idle(4);
                    m_f1 = 1;
                    check_model("R10 random port");
                end
            endcase
        end

        // R5 level mode on dut_lvl
        bus_write(RA, 8'h03);
        @(negedge clk); irq_b_n = 1'b0; idle(4);
        bus_write(RA, 8'h82);
        idle(1);
        bus_read(RA, da, db);
        check("R5 level re-sets after ack", db[3], 1'b1);
        check("R5 level req", req_b, 1'b1);
        irq_b_n = 1'b1; idle(4);
        bus_write(RA, 8'h82);
        bus_read(RA, da, db);
        check("R5 clears once high", db[3], 1'b0);
        check("R11 level out", lvl_b, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule